// File: doc/BRIEF.md
# FIFO Watermark Status and Interrupt Controller

This block sits beside the transmit and receive FIFOs of a serial peripheral. It takes the current fill level of each FIFO and turns it into three flags per FIFO: empty, half and full. The half flag is not tied to a fixed midpoint. It compares the level against a watermark that software programs, so software chooses how early it is told that a FIFO is filling or draining.

The six FIFO flags are joined by two event inputs: a transfer-done indication, and an error made from receive overflow or transmit underflow. These eight conditions are the interrupt sources. Each source has a sticky status bit that is set when its condition rises. Software clears a status bit by writing a one to the matching bit of a clear register. A per-source enable mask decides which status bits reach the single interrupt output.

A small register port with a write strobe and a combinational read gives access to the enable mask, the status, the clear register, both watermarks, the live source flags and both fill levels.

Top module: `fifo_wm_irq`

## Requirements
- R1: While reset is held and on the first cycle after it, the enable register reads 0, the status register reads 0, `irq` is 0, and both watermarks read DEPTH/2 (8 for the default depth of 16).
- R2: For each FIFO, the empty output is 1 exactly when its level is 0, and the full output is 1 exactly when its level equals DEPTH.
- R3: For each FIFO, the half output is 1 when its level is greater than or equal to that FIFO's watermark, and 0 when the level is below it.
- R4: The transmit watermark is at address 3 and the receive watermark is at address 4. Both can be written and read back. A written value above DEPTH is stored as DEPTH.
- R5: Address 6 reads the transmit level and address 7 reads the receive level. Address 5 reads the eight live source conditions in the bit order given in R6.
- R6: The source bits are: 0 transfer done, 1 error, 2 TX empty, 3 TX half, 4 TX full, 5 RX empty, 6 RX half, 7 RX full. A status bit (address 1) becomes 1 after the clock edge at which its source is 1 and was 0 on the previous edge. A source that is already 1 when reset ends counts as a rise.
- R7: A status bit stays 1 after its source falls. Writing 1 to a bit of the clear register (address 2) clears that status bit. Writing 0 leaves it unchanged. Address 2 reads 0.
- R8: When a bit's rising edge and a write of 1 to its clear bit happen on the same edge, the status bit ends up 1.
- R9: `irq` is 1 exactly when some status bit and its enable bit (address 0) are both 1. Status bits are set even while their enable bit is 0.
- R10: The error source is the OR of the receive-overflow and transmit-underflow inputs, so a rise on either input sets status bit 1.
- R11: Writes to the read-only addresses 1, 5, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | LVL_W (5) | Transmit FIFO fill level, 0..DEPTH |
| rx_level | input | LVL_W (5) | Receive FIFO fill level, 0..DEPTH |
| xfer_done | input | 1 | Transfer-done condition |
| rx_overflow | input | 1 | Receive overflow condition |
| tx_underflow | input | 1 | Transmit underflow condition |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_half | output | 1 | Transmit level at or above its watermark |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_half | output | 1 | Receive level at or above its watermark |
| rx_full | output | 1 | Receive FIFO full |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every fill level from 0 to DEPTH against watermarks of 0, 1, the midpoint, DEPTH-1 and DEPTH, where an off-by-one comparison would move the half flag by one level. From a clean base level it steps to each target level and checks which status bits rose. A design that set bits on the level instead of the edge, or that mapped a source to the wrong bit, would show the wrong mask here. It also checks the cases that are easy to get wrong: a clear on the same edge as a rise (a design that lets the clear win loses the event), status latching while the source is masked (a design that gates the set with the enable never raises `irq` later), saturation of oversized watermarks, and the empty flags that are already true when reset ends.

// File: rtl/fifo_wm_irq_pkg.sv
// Shared constants: register addresses and interrupt source bit positions.
package fifo_wm_irq_pkg;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 8;

    localparam logic [ADDR_W-1:0] A_IEN   = 3'd0;
    localparam logic [ADDR_W-1:0] A_ISTAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_ICLR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TXWM  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RXWM  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;
    localparam logic [ADDR_W-1:0] A_TXLVL = 3'd6;
    localparam logic [ADDR_W-1:0] A_RXLVL = 3'd7;

    localparam int S_DONE = 0;
    localparam int S_ERR  = 1;
    localparam int S_TXE  = 2;
    localparam int S_TXH  = 3;
    localparam int S_TXF  = 4;
    localparam int S_RXE  = 5;
    localparam int S_RXH  = 6;
    localparam int S_RXF  = 7;
endpackage

// File: rtl/wm_flags.sv
// wm_flags: empty / at-or-above-watermark / full flags for one FIFO.
// Assumes level never exceeds DEPTH and the watermark is saturated at DEPTH.
module wm_flags #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] wmark,
    output logic             empty,
    output logic             half,
    output logic             full
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    // Compare the level against zero, the watermark and the capacity.
    always_comb begin
        empty = (level == '0);
        half  = (level >= wmark);
        full  = (level == FULL_LVL);
    end

    // R3: a full FIFO is always at or above a saturated watermark
    assert_full_implies_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half);
    // R2: the level input stays within the FIFO capacity
    assert_level_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
endmodule

// File: rtl/irq_ctrl.sv
// irq_ctrl: rising-edge detection, sticky status with write-one-to-clear
// (set has priority), and the masked OR onto the interrupt line.
// Assumes clr is a single-cycle pulse vector from the register bank.
module irq_ctrl #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] enable,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] status,
    output logic            irq
);
    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] rise;

    // Remember each source from the previous edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    assign rise = src & ~src_q;

    // One sticky bit per source; a rise on the same edge overrides a clear.
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)       status[i] <= 1'b0;
            else if (rise[i]) status[i] <= 1'b1;
            else if (clr[i])  status[i] <= 1'b0;
        end

        // R8: a rise always leaves the bit set, even with a clear pending
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> status[i]);
        // R7: a clear without a rise empties the bit
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !rise[i]) |=> !status[i]);
        // R7: without a rise or a clear the bit holds
        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !rise[i]) |=> $stable(status[i]));
    end

    // Drive the interrupt when any enabled status bit is set.
    always_comb irq = |(status & enable);
endmodule

// File: rtl/reg_bank.sv
// reg_bank: enable mask and watermark registers, clear pulse generation and
// the combinational read mux. Assumes one write per cycle at most.
module reg_bank
    import fifo_wm_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] src,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    output logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] clr,
    output logic [LVL_W-1:0]   tx_wm,
    output logic [LVL_W-1:0]   rx_wm
);
    localparam logic [LVL_W-1:0] WM_RST = LVL_W'(DEPTH / 2);
    localparam logic [LVL_W-1:0] WM_MAX = LVL_W'(DEPTH);

    logic [LVL_W-1:0] wm_sat;

    // Saturate a written watermark at the FIFO depth.
    always_comb begin
        if (int'(wr_data) > DEPTH) wm_sat = WM_MAX;
        else                       wm_sat = wr_data[LVL_W-1:0];
    end

    // Hold the enable mask and both watermarks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
            tx_wm  <= WM_RST;
            rx_wm  <= WM_RST;
        end else if (wr_en) begin
            if (wr_addr == A_IEN)  enable <= wr_data[NUM_SRC-1:0];
            if (wr_addr == A_TXWM) tx_wm  <= wm_sat;
            if (wr_addr == A_RXWM) rx_wm  <= wm_sat;
        end
    end

    // Turn a write to the clear address into a one-cycle clear vector.
    always_comb clr = (wr_en && wr_addr == A_ICLR) ? wr_data[NUM_SRC-1:0] : '0;

    // Select the read data by address.
    always_comb begin
        unique case (rd_addr)
            A_IEN:   rd_data = DATA_W'(enable);
            A_ISTAT: rd_data = DATA_W'(status);
            A_TXWM:  rd_data = DATA_W'(tx_wm);
            A_RXWM:  rd_data = DATA_W'(rx_wm);
            A_FLAGS: rd_data = DATA_W'(src);
            A_TXLVL: rd_data = DATA_W'(tx_level);
            A_RXLVL: rd_data = DATA_W'(rx_level);
            default: rd_data = '0;
        endcase
    end

    // R4: the stored watermarks never exceed the depth
    assert_wm_saturated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wm <= WM_MAX) && (rx_wm <= WM_MAX));
    // R11: the enable mask moves only on a write to its own address
    assert_enable_write_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_IEN) |=> $stable(enable));
endmodule

// File: rtl/fifo_wm_irq.sv
// fifo_wm_irq: top level. Builds the eight interrupt sources from two FIFO
// flag generators and the event inputs, and ties them to the register bank
// and the interrupt controller. Assumes levels are synchronous to clk.
module fifo_wm_irq
    import fifo_wm_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              xfer_done,
    input  logic              rx_overflow,
    input  logic              tx_underflow,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              tx_half,
    output logic              tx_full,
    output logic              rx_empty,
    output logic              rx_half,
    output logic              rx_full,
    output logic              irq
);
    localparam int NFIFO = 2;

    logic [NFIFO-1:0][LVL_W-1:0] lvl_arr;
    logic [NFIFO-1:0][LVL_W-1:0] wm_arr;
    logic [NFIFO-1:0]            emp_arr, half_arr, full_arr;
    logic [LVL_W-1:0]            tx_wm, rx_wm;
    logic [NUM_SRC-1:0]          src, enable, clr, status;

    assign lvl_arr = {rx_level, tx_level};
    assign wm_arr  = {rx_wm, tx_wm};

    // One flag generator per FIFO (index 0 transmit, 1 receive).
    for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
        wm_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flags (
            .clk   (clk),
            .rst_n (rst_n),
            .level (lvl_arr[f]),
            .wmark (wm_arr[f]),
            .empty (emp_arr[f]),
            .half  (half_arr[f]),
            .full  (full_arr[f])
        );
    end

    // Gather the eight interrupt sources in their fixed bit order.
    always_comb begin
        src         = '0;
        src[S_DONE] = xfer_done;
        src[S_ERR]  = rx_overflow | tx_underflow;
        src[S_TXE]  = emp_arr[0];
        src[S_TXH]  = half_arr[0];
        src[S_TXF]  = full_arr[0];
        src[S_RXE]  = emp_arr[1];
        src[S_RXH]  = half_arr[1];
        src[S_RXF]  = full_arr[1];
    end

    assign tx_empty = emp_arr[0];
    assign tx_half  = half_arr[0];
    assign tx_full  = full_arr[0];
    assign rx_empty = emp_arr[1];
    assign rx_half  = half_arr[1];
    assign rx_full  = full_arr[1];

    reg_bank #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .status   (status),
        .src      (src),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .enable   (enable),
        .clr      (clr),
        .tx_wm    (tx_wm),
        .rx_wm    (rx_wm)
    );

    irq_ctrl #(.NSRC(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src),
        .enable (enable),
        .clr    (clr),
        .status (status),
        .irq    (irq)
    );

    // R9: with nothing enabled the interrupt line stays low
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);
    // R6: the status register cannot gain a bit whose source is low
    assert_set_needs_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) & ~$past(src)) == '0);
endmodule

// File: tb/fifo_wm_irq_tb.sv
// Self-checking bench: sweeps levels against watermarks and exercises the
// sticky interrupt logic, with expectations computed arithmetically.
module fifo_wm_irq_tb;
    localparam int DEPTH = 16;
    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
    logic             xfer_done = 1'b0, rx_overflow = 1'b0, tx_underflow = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0, rd_addr = '0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_data;
    logic             tx_empty, tx_half, tx_full, rx_empty, rx_half, rx_full, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    fifo_wm_irq #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .xfer_done(xfer_done), .rx_overflow(rx_overflow), .tx_underflow(tx_underflow),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .tx_empty(tx_empty), .tx_half(tx_half), .tx_full(tx_full),
        .rx_empty(rx_empty), .rx_half(rx_half), .rx_full(rx_full), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_lvl(input int t, input int r);
        @(negedge clk);
        tx_level = LVL_W'(t); rx_level = LVL_W'(r);
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v;
        int wms[5] = '{0, 1, 8, 15, 16};
        tx_level = 5'd4; rx_level = 5'd4;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        rd(3'd0, v); check("R1 enable", v, 0);
        rd(3'd1, v); check("R1 status", v, 0);
        rd(3'd3, v); check("R1 txwm", v, DEPTH / 2);
        rd(3'd4, v); check("R1 rxwm", v, DEPTH / 2);
        check("R1 irq", int'(irq), 0);

        // R6: an empty FIFO at reset release counts as a rise
        set_lvl(0, 0);
        @(negedge clk) rst_n = 1'b1;
        tick();
        rd(3'd1, v); check("R6 rise out of reset", v, 8'h24);
        check("R1 irq after reset", int'(irq), 0);

        // R2 R3 R4: sweep every level against boundary watermarks
        foreach (wms[k]) begin
            wr(3'd3, wms[k]);
            wr(3'd4, wms[k]);
            rd(3'd3, v); check("R4 txwm readback", v, wms[k]);
            rd(3'd4, v); check("R4 rxwm readback", v, wms[k]);
            for (int l = 0; l <= DEPTH; l++) begin
                set_lvl(l, DEPTH - l);
                #1;
                check("R2 tx_empty", int'(tx_empty), int'(l == 0));
                check("R2 tx_full",  int'(tx_full),  int'(l == DEPTH));
                check("R3 tx_half",  int'(tx_half),  int'(l >= wms[k]));
                check("R2 rx_empty", int'(rx_empty), int'(l == DEPTH));
                check("R2 rx_full",  int'(rx_full),  int'(l == 0));
                check("R3 rx_half",  int'(rx_half),  int'((DEPTH - l) >= wms[k]));
                rd(3'd6, v); check("R5 tx level", v, l);
                rd(3'd7, v); check("R5 rx level", v, DEPTH - l);
                rd(3'd5, v);
                check("R5 flag word", v,
                      (int'(l == 0) << 2) | (int'(l >= wms[k]) << 3) | (int'(l == DEPTH) << 4) |
                      (int'(l == DEPTH) << 5) | (int'((DEPTH - l) >= wms[k]) << 6) |
                      (int'(l == 0) << 7));
            end
        end

        // R4: oversized watermark saturates
        wr(3'd3, 31);  rd(3'd3, v); check("R4 tx saturate", v, DEPTH);
        wr(3'd4, 200); rd(3'd4, v); check("R4 rx saturate", v, DEPTH);
        wr(3'd3, 8);   wr(3'd4, 8);

        // R6: per-level rising-edge mapping for both FIFOs from a base of 4
        for (int l = 0; l <= DEPTH; l++) begin
            set_lvl(4, 4);
            tick();
            wr(3'd2, 8'hFF);
            rd(3'd1, v); check("R7 clear all", v, 0);
            set_lvl(l, 4);
            tick();
            rd(3'd1, v);
            check("R6 tx source bits", v,
                  (int'(l == 0) << 2) | (int'(l >= 8) << 3) | (int'(l == DEPTH) << 4));
            set_lvl(4, 4);
            tick();
            wr(3'd2, 8'hFF);
            set_lvl(4, l);
            tick();
            rd(3'd1, v);
            check("R6 rx source bits", v,
                  (int'(l == 0) << 5) | (int'(l >= 8) << 6) | (int'(l == DEPTH) << 7));
        end
        set_lvl(4, 4);
        tick();
        wr(3'd2, 8'hFF);

        // R9 R7: done event, sticky, write-zero no effect, clear
        wr(3'd0, 8'h01);
        @(negedge clk) xfer_done = 1'b1;
        tick();
        rd(3'd1, v); check("R6 done bit0", v, 8'h01);
        check("R9 irq on enabled bit", int'(irq), 1);
        @(negedge clk) xfer_done = 1'b0;
        tick();
        rd(3'd1, v); check("R7 sticky after fall", v, 8'h01);
        wr(3'd2, 8'h00);
        rd(3'd1, v); check("R7 write zero keeps", v, 8'h01);
        wr(3'd2, 8'h01);
        rd(3'd1, v); check("R7 clear bit0", v, 0);
        check("R9 irq drops", int'(irq), 0);

        // R8: rise and clear on the same edge
        @(negedge clk) xfer_done = 1'b1;
        tick();
        @(negedge clk) xfer_done = 1'b0;
        tick();
        @(negedge clk);
        xfer_done = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h01;
        tick();
        wr_en = 1'b0;
        rd(3'd1, v); check("R8 set wins", v, 8'h01);
        @(negedge clk) xfer_done = 1'b0;
        wr(3'd2, 8'h01);
        rd(3'd1, v); check("R8 later clear", v, 0);

        // R9 R10: latch while masked, overflow source
        wr(3'd0, 8'h00);
        @(negedge clk) rx_overflow = 1'b1;
        tick();
        @(negedge clk) rx_overflow = 1'b0;
        tick();
        rd(3'd1, v); check("R10 overflow sets err", v, 8'h02);
        check("R9 masked irq low", int'(irq), 0);
        wr(3'd0, 8'h02);
        check("R9 irq after enable", int'(irq), 1);
        wr(3'd0, 8'hFD);
        check("R9 other enables only", int'(irq), 0);
        wr(3'd2, 8'h02);
        @(negedge clk) tx_underflow = 1'b1;
        tick();
        @(negedge clk) tx_underflow = 1'b0;
        rd(3'd1, v); check("R10 underflow sets err", v, 8'h02);
        wr(3'd2, 8'hFF);

        // R11: writes to read-only addresses change nothing
        wr(3'd1, 8'hFF);
        rd(3'd1, v); check("R11 status write ignored", v, 0);
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd0, v); check("R11 enable unchanged", v, 8'hFD);
        rd(3'd3, v); check("R11 txwm unchanged", v, 8);
        rd(3'd4, v); check("R11 rxwm unchanged", v, 8);
        rd(3'd1, v); check("R11 status unchanged", v, 0);
        rd(3'd2, v); check("R7 clear reads zero", v, 0);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule